// File: doc/BRIEF.md
# Protocol Reply Header Builder

This block turns the decoded header fields of a received Ethernet frame into the header fields of the frame that answers it. It covers three cases: an ARP request, an ICMP echo request carried in IPv4, and a UDP datagram carried in IPv4. Upstream logic presents each header as one wide vector and names the expected case with a two-bit selector. A single-cycle start strobe then captures the rewritten reply into output registers.

One clock after start, a done strobe marks the reply as ready. A flag tells whether the frame earned a reply at all. The rewrite swaps the Ethernet, ARP, IPv4 and UDP addresses and ports, turns the ARP operation and the ICMP message type into their reply values, and copies the remaining fields unchanged. Every checksum field is loaded with a fixed initial value, for a later stage to fill in.

Top module: `reply_hdr_builder`

## Requirements
- R1: `done` is high in the cycle right after each cycle in which `start` was sampled high, and low in every other cycle.
- R2: After reset, `reply_ok`, `done` and all five reply header outputs are zero.
- R3: Outside a start, `reply_ok` and all reply header outputs keep their values, whatever the inputs do in the meantime.
- R4: The Ethernet vector is {align[127:112], dst[111:64], src[63:16], type[15:0]}. In an accepted reply, dst takes the received src, src takes the received dst, and align and type are copied.
- R5: A reply is accepted (`reply_ok`=1) in exactly three cases, and in no other case:
  - sel=0 with type 0x0806 and ARP operation 1;
  - sel=1 with type 0x0800, IP protocol 1 and ICMP type 8;
  - sel=2 with type 0x0800 and IP protocol 17.

  sel=3 is never accepted. A frame that is not accepted gives all-zero header outputs.
- R6: The ARP vector is {htype[223:208], ptype[207:192], hlen[191:184], plen[183:176], oper[175:160], sha[159:112], spa[111:80], tha[79:32], tpa[31:0]}. In an ARP reply:
  - oper becomes 2;
  - sha takes the received tha, and tha takes the received sha;
  - spa takes the received tpa, and tpa takes the received spa;
  - htype, ptype, hlen and plen are copied.
- R7: The IPv4 vector is {ver[159:156], ihl[155:152], tos[151:144], len[143:128], id[127:112], flags[111:109], frag[108:96], ttl[95:88], proto[87:80], csum[79:64], src[63:32], dst[31:0]}. In an ICMP or UDP reply, src and dst are swapped, csum becomes the initial value 0x0000, and all other fields are copied.
- R8: The ICMP vector is {type[63:56], code[55:48], csum[47:32], id[31:16], seq[15:0]}. In an ICMP reply, type becomes 0, csum becomes 0x0000, and code, id and seq are copied.
- R9: The UDP vector is {sport[63:48], dport[47:32], len[31:16], csum[15:0]}. In a UDP reply, the ports are swapped, len is copied and csum becomes 0x0000.
- R10: Sub-headers that do not belong to the accepted case are zero:
  - an ARP reply has zero IPv4, ICMP and UDP outputs;
  - an ICMP reply has zero ARP and UDP outputs;
  - a UDP reply has zero ARP and ICMP outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture strobe for the reply |
| proto_sel | input | 2 | Expected case: 0 ARP, 1 ICMP, 2 UDP |
| rx_eth | input | 128 | Received Ethernet header fields |
| rx_arp | input | 224 | Received ARP packet fields |
| rx_ip | input | 160 | Received IPv4 header fields |
| rx_icmp | input | 64 | Received ICMP header fields |
| rx_udp | input | 64 | Received UDP header fields |
| done | output | 1 | Reply ready, one cycle after start |
| reply_ok | output | 1 | The frame earned a reply |
| tx_eth | output | 128 | Reply Ethernet header fields |
| tx_arp | output | 224 | Reply ARP packet fields |
| tx_ip | output | 160 | Reply IPv4 header fields |
| tx_icmp | output | 64 | Reply ICMP header fields |
| tx_udp | output | 64 | Reply UDP header fields |

## Verification
The hardest cases to reach are frames that miss acceptance by a single field: the right selector with the wrong EtherType, an ARP reply presented as a request, an ICMP type other than echo request, or an IP protocol that does not match the selector. Random field values almost never produce these cases. The stimulus therefore first builds a well-formed frame for a random selector and then, half of the time, corrupts exactly one of the deciding fields. Back-to-back starts and idle gaps with scrambled inputs are mixed in, so that both the one-cycle done timing and the hold behaviour are compared against the model every clock.

// File: rtl/reply_hdr_builder.sv
module reply_hdr_builder #(
  parameter logic [15:0] ETYPE_ARP  = 16'h0806,
  parameter logic [15:0] ETYPE_IPV4 = 16'h0800,
  parameter logic [15:0] CSUM_INIT  = 16'h0000,
  parameter logic [7:0]  ICMP_REQ   = 8'd8,
  parameter logic [7:0]  ICMP_REP   = 8'd0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   proto_sel,
  input  logic [127:0] rx_eth,
  input  logic [223:0] rx_arp,
  input  logic [159:0] rx_ip,
  input  logic [63:0]  rx_icmp,
  input  logic [63:0]  rx_udp,
  output logic         done,
  output logic         reply_ok,
  output logic [127:0] tx_eth,
  output logic [223:0] tx_arp,
  output logic [159:0] tx_ip,
  output logic [63:0]  tx_icmp,
  output logic [63:0]  tx_udp
);

  localparam logic [1:0]  SEL_ARP   = 2'd0;
  localparam logic [1:0]  SEL_ICMP  = 2'd1;
  localparam logic [1:0]  SEL_UDP   = 2'd2;
  localparam logic [15:0] ARP_REQ   = 16'd1;
  localparam logic [15:0] ARP_REP   = 16'd2;
  localparam logic [7:0]  IPP_ICMP  = 8'd1;
  localparam logic [7:0]  IPP_UDP   = 8'd17;

  logic [15:0] etype;
  logic        is_ipv4, hit_arp, hit_icmp, hit_udp, hit_any;
  logic [127:0] nx_eth;
  logic [223:0] nx_arp;
  logic [159:0] nx_ip;
  logic [63:0]  nx_icmp, nx_udp;

  assign etype    = rx_eth[15:0];
  assign is_ipv4  = (etype == ETYPE_IPV4);
  assign hit_arp  = (proto_sel == SEL_ARP) && (etype == ETYPE_ARP) && (rx_arp[175:160] == ARP_REQ);
  assign hit_icmp = (proto_sel == SEL_ICMP) && is_ipv4 && (rx_ip[87:80] == IPP_ICMP)
                    && (rx_icmp[63:56] == ICMP_REQ);
  assign hit_udp  = (proto_sel == SEL_UDP) && is_ipv4 && (rx_ip[87:80] == IPP_UDP);
  assign hit_any  = hit_arp | hit_icmp | hit_udp;

  assign nx_eth  = hit_any ? {rx_eth[127:112], rx_eth[63:16], rx_eth[111:64], rx_eth[15:0]} : '0;
  assign nx_arp  = hit_arp ? {rx_arp[223:176], ARP_REP, rx_arp[79:32], rx_arp[31:0],
                              rx_arp[159:112], rx_arp[111:80]} : '0;
  assign nx_ip   = (hit_icmp | hit_udp) ? {rx_ip[159:80], CSUM_INIT, rx_ip[31:0], rx_ip[63:32]} : '0;
  assign nx_icmp = hit_icmp ? {ICMP_REP, rx_icmp[55:48], CSUM_INIT, rx_icmp[31:0]} : '0;
  assign nx_udp  = hit_udp ? {rx_udp[47:32], rx_udp[63:48], rx_udp[31:16], CSUM_INIT} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      reply_ok <= 1'b0;
      tx_eth   <= '0;
      tx_arp   <= '0;
      tx_ip    <= '0;
      tx_icmp  <= '0;
      tx_udp   <= '0;
    end else begin
      done <= start;
      if (start) begin
        reply_ok <= hit_any;
        tx_eth   <= nx_eth;
        tx_arp   <= nx_arp;
        tx_ip    <= nx_ip;
        tx_icmp  <= nx_icmp;
        tx_udp   <= nx_udp;
      end
    end
  end

  a_r1_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  a_r3_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(reply_ok) && $stable(tx_eth) && $stable(tx_arp) && $stable(tx_ip)
                && $stable(tx_icmp) && $stable(tx_udp)));
  a_r4_mac_swap: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!reply_ok || (tx_eth[111:64] == $past(rx_eth[63:16])
                             && tx_eth[63:16] == $past(rx_eth[111:64]))));
  a_r5_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reply_ok) |-> (tx_eth == '0 && tx_arp == '0 && tx_ip == '0
                             && tx_icmp == '0 && tx_udp == '0));
  a_r6_arp_oper: assert property (@(posedge clk) disable iff (!rst_n)
    (done && reply_ok && tx_eth[15:0] == ETYPE_ARP) |-> (tx_arp[175:160] == ARP_REP));
  a_r10_one_family: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !((|tx_arp) && ((|tx_ip) || (|tx_icmp) || (|tx_udp))));
  a_r10_icmp_udp_apart: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({|tx_icmp, |tx_udp}) <= 1);

endmodule

// File: tb/sim_reply_hdr_builder.sv
module sim_reply_hdr_builder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] proto_sel = '0;
  logic [127:0] rx_eth = '0;
  logic [223:0] rx_arp = '0;
  logic [159:0] rx_ip = '0;
  logic [63:0] rx_icmp = '0, rx_udp = '0;
  logic done, reply_ok;
  logic [127:0] tx_eth;
  logic [223:0] tx_arp;
  logic [159:0] tx_ip;
  logic [63:0] tx_icmp, tx_udp;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reply_hdr_builder u0 (.*);

  logic m_done, m_ok;
  logic [127:0] m_eth;
  logic [223:0] m_arp;
  logic [159:0] m_ip;
  logic [63:0] m_icmp, m_udp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done <= 0; m_ok <= 0; m_eth <= 0; m_arp <= 0; m_ip <= 0; m_icmp <= 0; m_udp <= 0;
    end else begin
      m_done <= start;
      if (start) begin
        logic ok; logic [127:0] e; logic [223:0] a; logic [159:0] ip;
        logic [63:0] ic, ud; int kind;
        kind = -1;
        if (proto_sel == 0 && rx_eth[15:0] == 16'h0806 && rx_arp[175:160] == 16'd1) kind = 0;
        if (proto_sel == 1 && rx_eth[15:0] == 16'h0800 && rx_ip[87:80] == 8'd1
            && rx_icmp[63:56] == 8'd8) kind = 1;
        if (proto_sel == 2 && rx_eth[15:0] == 16'h0800 && rx_ip[87:80] == 8'd17) kind = 2;
        ok = (kind >= 0);
        e = 0; a = 0; ip = 0; ic = 0; ud = 0;
        if (ok) begin
          e[127:112] = rx_eth[127:112]; e[15:0] = rx_eth[15:0];
          e[111:64] = rx_eth[63:16];    e[63:16] = rx_eth[111:64];
        end
        if (kind == 0) begin
          a = rx_arp;
          a[175:160] = 16'd2;
          a[159:112] = rx_arp[79:32];  a[79:32] = rx_arp[159:112];
          a[111:80]  = rx_arp[31:0];   a[31:0]  = rx_arp[111:80];
        end
        if (kind == 1 || kind == 2) begin
          ip = rx_ip;
          ip[79:64] = 16'h0000;
          ip[63:32] = rx_ip[31:0]; ip[31:0] = rx_ip[63:32];
        end
        if (kind == 1) begin
          ic = rx_icmp; ic[63:56] = 8'd0; ic[47:32] = 16'h0000;
        end
        if (kind == 2) begin
          ud[63:48] = rx_udp[47:32]; ud[47:32] = rx_udp[63:48];
          ud[31:16] = rx_udp[31:16]; ud[15:0] = 16'h0000;
        end
        m_ok <= ok; m_eth <= e; m_arp <= a; m_ip <= ip; m_icmp <= ic; m_udp <= ud;
      end
    end
  end

  task automatic chk(input string tag, input logic [223:0] act, input logic [223:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0t act=%h exp=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk("R1 done", {223'd0, done}, {223'd0, m_done});
    chk("R5 reply_ok", {223'd0, reply_ok}, {223'd0, m_ok});
    chk("R4 eth", {96'd0, tx_eth}, {96'd0, m_eth});
    chk("R6 arp", tx_arp, m_arp);
    chk("R7 ip", {64'd0, tx_ip}, {64'd0, m_ip});
    chk("R8 icmp", {160'd0, tx_icmp}, {160'd0, m_icmp});
    chk("R9 udp", {160'd0, tx_udp}, {160'd0, m_udp});
  end

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic scramble();
    rx_eth = rnd256()[127:0]; rx_arp = rnd256()[223:0]; rx_ip = rnd256()[159:0];
    rx_icmp = rnd256()[63:0]; rx_udp = rnd256()[63:0];
  endtask

  // sel: 0 ARP, 1 ICMP, 2 UDP, 3 none; flaw: 0 clean, 1 etype, 2 oper/type, 3 protocol
  task automatic make_frame(input int sel, input int flaw);
    scramble();
    proto_sel = sel[1:0];
    rx_eth[15:0] = (sel == 0) ? 16'h0806 : 16'h0800;
    rx_arp[175:160] = 16'd1;
    rx_ip[87:80] = (sel == 2) ? 8'd17 : 8'd1;
    rx_icmp[63:56] = 8'd8;
    case (flaw)
      1: rx_eth[15:0] = (sel == 0) ? 16'h0800 : 16'h0806;
      2: begin rx_arp[175:160] = 16'd2; rx_icmp[63:56] = 8'd0; end
      3: rx_ip[87:80] = (sel == 2) ? 8'd1 : 8'd17;
      default: ;
    endcase
  endtask

  task automatic pulse();
    start = 1; @(negedge clk); start = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    scramble();
    repeat (3) @(negedge clk);
    // R2: reset values compared by the per-clock model check
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 4; f++) begin
        make_frame(s, f); pulse();
        scramble(); @(negedge clk); // R3: inputs change with no start
        @(negedge clk);
      end
    // R1: back-to-back starts
    for (int i = 0; i < 40; i++) begin
      make_frame($urandom_range(0, 3), $urandom_range(0, 1) ? 0 : $urandom_range(1, 3));
      start = 1; @(negedge clk);
    end
    start = 0;
    for (int i = 0; i < 400; i++) begin
      make_frame($urandom_range(0, 2), $urandom_range(0, 1) ? 0 : $urandom_range(1, 3));
      start = $urandom_range(0, 1);
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) scramble();
    end
    start = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule